// File: doc/BRIEF.md
# Transmit Start Threshold Controller

This block decides the cycle in which the transmit engine may begin sending the packet that is being queued in the transmit FIFO. It watches how many bytes of the current packet are held in the FIFO, whether the packet's last byte has been written, and a selectable fill level. In cut-through mode it launches once the fill level is reached, or earlier if the whole packet is already present. In store-and-forward mode it ignores the fill level and waits for the complete packet.

Once a packet is launched, the controller watches the transmitter. If the FIFO runs dry before the transmitter has read the packet's end, that is an underflow. A jabber timeout from the transmitter is also a fault. Either fault halts the controller and sets a sticky error flag, which is cleared by a write-one-to-clear strobe. After reset, and after any halt, transmission does not resume by itself. The run enable must be set, and a poll-demand pulse must arrive while a packet is available. The FIFO holds 2048 bytes, and the fill levels are powers of two from 128 to 1024 bytes.

Top module: `txq_launch_ctrl`

## Requirements
- R1: While reset is high, and at the first edge after it, `halted` reads 1 and `tx_start`, `underflow_err` and `jabber_err` read 0.
- R2: The controller leaves the halted state only when `run_en` and `poll_req` are both high while a packet is available. A packet is available when `fifo_bytes` is nonzero or `eop_written` is 1. Without a poll pulse it stays halted. A poll pulse is ignored if `run_en` is low or no packet is available.
- R3: With `sf_mode` = 0, a launch is issued once `fifo_bytes` reaches at least the selected level. The level is 128 bytes for `thr_sel` = 0, 256 for 1, 512 for 2 and 1024 for 3. One byte less does not launch.
- R4: With `sf_mode` = 0, `eop_written` = 1 launches regardless of `fifo_bytes`.
- R5: With `sf_mode` = 1, only `eop_written` = 1 launches, even with the FIFO full at 2048 bytes.
- R6: Each launch is a single-cycle `tx_start` pulse, followed by no other pulse until `tx_done`. No launch is issued while `tx_busy` is 1.
- R7: After a launch, `fifo_empty` = 1 with `tx_done` = 0 halts the controller and sets `underflow_err`. When `fifo_empty` and `tx_done` are both 1, this is a normal finish and no fault.
- R8: `jabber_to` = 1 while not halted halts the controller and sets `jabber_err`.
- R9: Each error flag stays set until its clear strobe. The clear resets the flag at the next edge. If a new fault arrives in the same cycle as the clear, the fault wins.
- R10: `run_en` = 0 while armed halts the controller at once. While a packet is being sent, it halts the controller at `tx_done`.
- R11: Every output is registered and reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_bytes | input | 12 | Bytes of the current packet held in the FIFO |
| eop_written | input | 1 | The current packet's last byte is in the FIFO |
| thr_sel | input | 2 | Fill level code (128 << code bytes) |
| sf_mode | input | 1 | Store-and-forward: wait for the whole packet |
| run_en | input | 1 | Transmit run enable |
| poll_req | input | 1 | Poll-demand pulse |
| tx_busy | input | 1 | Transmitter still sending a previous packet |
| tx_done | input | 1 | Transmitter has read the packet's end |
| fifo_empty | input | 1 | FIFO has no bytes for the transmitter |
| jabber_to | input | 1 | Transmit jabber timeout |
| clr_underflow | input | 1 | Write-one-to-clear strobe for `underflow_err` |
| clr_jabber | input | 1 | Write-one-to-clear strobe for `jabber_err` |
| tx_start | output | 1 | One-cycle launch pulse |
| halted | output | 1 | Transmit activity stopped |
| underflow_err | output | 1 | Sticky underflow flag |
| jabber_err | output | 1 | Sticky jabber flag |

## Verification
Every result of this block, whether launch pulse, halt status or error flag, is due exactly one rising edge after the inputs that cause it. The bench drives inputs on the falling edge, waits for one rising edge, and samples on the next falling edge. Each check therefore looks at the cycle in which the response must first appear. Multi-cycle properties, such as pulse width, stickiness and hold-off, are checked by stepping further edges with the inputs held and sampling each one the same way.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } launch_state_e;
endpackage

// File: rtl/txq_fill_judge.sv
// Decides whether the queued packet is ready to launch, from fill level,
// end-of-packet presence and the store-and-forward mode.
module txq_fill_judge #(
  parameter int CNT_W    = 12,
  parameter int CODE_W   = 2,
  parameter int BASE_THR = 128
) (
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              eop_written,
  input  logic [CODE_W-1:0] thr_sel,
  input  logic              sf_mode,
  output logic              ready
);
  localparam int LEVELS = 2 ** CODE_W;

  logic [LEVELS-1:0] hit;

  // One comparator per selectable level; the code picks one of them.
  for (genvar i = 0; i < LEVELS; i++) begin : g_level
    localparam int LVL = BASE_THR << i;
    assign hit[i] = (fifo_bytes >= CNT_W'(LVL));
  end

  always_comb begin
    if (sf_mode) ready = eop_written;
    else         ready = eop_written | hit[thr_sel];
  end
endmodule

// File: rtl/txq_fault_latch.sv
// Sticky fault flag, write-one-to-clear; a fault in the clear cycle wins.
module txq_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_evt) |=> !flag);
endmodule

// File: rtl/txq_launch_fsm.sv
// Halt / armed / sending sequencer with registered launch and halt outputs.
module txq_launch_fsm
  import txq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic poll_req,
  input  logic pkt_avail,
  input  logic ready,
  input  logic tx_busy,
  input  logic tx_done,
  input  logic fifo_empty,
  input  logic jabber_to,
  output logic tx_start,
  output logic halted,
  output logic uflow_evt,
  output logic jab_evt
);
  launch_state_e state_q, state_d;
  logic          launch;

  always_comb begin
    jab_evt   = (state_q != ST_HALT) && jabber_to;
    uflow_evt = (state_q == ST_SEND) && fifo_empty && !tx_done && !jabber_to;
    launch    = 1'b0;
    state_d   = state_q;
    unique case (state_q)
      ST_HALT: begin
        if (run_en && poll_req && pkt_avail) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (jab_evt)                   state_d = ST_HALT;
        else if (!run_en)              state_d = ST_HALT;
        else if (ready && !tx_busy) begin
          state_d = ST_SEND;
          launch  = 1'b1;
        end
      end
      ST_SEND: begin
        if (jab_evt || uflow_evt)      state_d = ST_HALT;
        else if (tx_done)              state_d = run_en ? ST_ARMED : ST_HALT;
      end
      default:                         state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HALT;
      tx_start <= 1'b0;
      halted   <= 1'b1;
    end else begin
      state_q  <= state_d;
      tx_start <= launch;
      halted   <= (state_d == ST_HALT);
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);
  a_r6_not_busy: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(!tx_busy && run_en));
  a_r2_restart_needs_poll: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> $past(run_en && poll_req));
  a_r8_jabber_halts: assert property (@(posedge clk) disable iff (rst)
    (jabber_to && !halted) |=> halted);
endmodule

// File: rtl/txq_launch_ctrl.sv
// Transmit start threshold controller (top).
module txq_launch_ctrl #(
  parameter int FIFO_BYTES = 2048,
  parameter int CODE_W     = 2,
  parameter int BASE_THR   = 128,
  localparam int CNT_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              eop_written,
  input  logic [CODE_W-1:0] thr_sel,
  input  logic              sf_mode,
  input  logic              run_en,
  input  logic              poll_req,
  input  logic              tx_busy,
  input  logic              tx_done,
  input  logic              fifo_empty,
  input  logic              jabber_to,
  input  logic              clr_underflow,
  input  logic              clr_jabber,
  output logic              tx_start,
  output logic              halted,
  output logic              underflow_err,
  output logic              jabber_err
);
  logic ready, pkt_avail, uflow_evt, jab_evt;

  assign pkt_avail = (fifo_bytes != '0) || eop_written;

  txq_fill_judge #(.CNT_W(CNT_W), .CODE_W(CODE_W), .BASE_THR(BASE_THR)) u_judge (
    .fifo_bytes (fifo_bytes),
    .eop_written(eop_written),
    .thr_sel    (thr_sel),
    .sf_mode    (sf_mode),
    .ready      (ready)
  );

  txq_launch_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .poll_req  (poll_req),
    .pkt_avail (pkt_avail),
    .ready     (ready),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .fifo_empty(fifo_empty),
    .jabber_to (jabber_to),
    .tx_start  (tx_start),
    .halted    (halted),
    .uflow_evt (uflow_evt),
    .jab_evt   (jab_evt)
  );

  txq_fault_latch u_uflow (
    .clk(clk), .rst(rst), .set_evt(uflow_evt), .clr_req(clr_underflow), .flag(underflow_err)
  );

  txq_fault_latch u_jab (
    .clk(clk), .rst(rst), .set_evt(jab_evt), .clr_req(clr_jabber), .flag(jabber_err)
  );

  a_r7_underflow_halts: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow_err) |-> halted);
  a_r5_sf_waits_eop: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(!sf_mode || eop_written));
  a_r3_level_or_eop: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(eop_written || fifo_bytes >= CNT_W'(BASE_THR)));
endmodule

// File: tb/txq_launch_ctrl_bench.sv
module txq_launch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {sf_mode, thr_sel, eop_written, fifo_bytes[11:0], expected tx_start}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 12'd127,  1'b0},  // R3 just below 128
    {1'b0, 2'd0, 1'b0, 12'd128,  1'b1},  // R3
    {1'b0, 2'd1, 1'b0, 12'd255,  1'b0},
    {1'b0, 2'd1, 1'b0, 12'd256,  1'b1},
    {1'b0, 2'd2, 1'b0, 12'd511,  1'b0},
    {1'b0, 2'd2, 1'b0, 12'd512,  1'b1},
    {1'b0, 2'd3, 1'b0, 12'd1023, 1'b0},
    {1'b0, 2'd3, 1'b0, 12'd1024, 1'b1},
    {1'b0, 2'd0, 1'b0, 12'd2048, 1'b1},
    {1'b0, 2'd3, 1'b1, 12'd10,   1'b1},  // R4 end present, below level
    {1'b1, 2'd0, 1'b0, 12'd2048, 1'b0},  // R5 full FIFO, no end
    {1'b1, 2'd0, 1'b0, 12'd200,  1'b0},  // R5 level met, no end
    {1'b1, 2'd3, 1'b1, 12'd5,    1'b1}   // R5 end present
  };

  logic clk = 1'b0;
  logic rst;
  logic [11:0] fifo_bytes;
  logic eop_written, sf_mode, run_en, poll_req, tx_busy, tx_done;
  logic fifo_empty, jabber_to, clr_underflow, clr_jabber;
  logic [1:0] thr_sel;
  logic tx_start, halted, underflow_err, jabber_err;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_launch_ctrl u_txq_launch_ctrl (
    .clk(clk), .rst(rst), .fifo_bytes(fifo_bytes), .eop_written(eop_written),
    .thr_sel(thr_sel), .sf_mode(sf_mode), .run_en(run_en), .poll_req(poll_req),
    .tx_busy(tx_busy), .tx_done(tx_done), .fifo_empty(fifo_empty),
    .jabber_to(jabber_to), .clr_underflow(clr_underflow), .clr_jabber(clr_jabber),
    .tx_start(tx_start), .halted(halted), .underflow_err(underflow_err),
    .jabber_err(jabber_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; fifo_bytes = '0; eop_written = 0; thr_sel = 0; sf_mode = 0;
    run_en = 0; poll_req = 0; tx_busy = 0; tx_done = 0; fifo_empty = 0;
    jabber_to = 0; clr_underflow = 0; clr_jabber = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic arm();
    run_en = 1; poll_req = 1; fifo_bytes = 12'd1; eop_written = 0;
    step();
    poll_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 halted", halted, 1'b1);
    check("R1 tx_start", tx_start, 1'b0);
    check("R1 underflow_err", underflow_err, 1'b0);
    check("R1 jabber_err", jabber_err, 1'b0);

    // Table walk of fill-level, end-of-packet and store-and-forward cases
    for (int i = 0; i < NV; i++) begin
      do_reset();
      arm();
      sf_mode = VEC[i][16]; thr_sel = VEC[i][15:14];
      eop_written = VEC[i][13]; fifo_bytes = VEC[i][12:1];
      step();
      check(VEC[i][16] ? "R5 vector" : (VEC[i][13] ? "R4 vector" : "R3 vector"),
            tx_start, VEC[i][0]);
    end

    // R2: poll needed, run_en and packet needed
    do_reset();
    run_en = 1; fifo_bytes = 12'd300; step(); step();
    check("R2 no poll stays halted", halted, 1'b1);
    run_en = 0; poll_req = 1; step(); poll_req = 0;
    check("R2 poll without run_en", halted, 1'b1);
    run_en = 1; fifo_bytes = '0; poll_req = 1; step(); poll_req = 0;
    check("R2 poll without packet", halted, 1'b1);
    eop_written = 1; poll_req = 1; step(); poll_req = 0;
    check("R2 poll with end present", halted, 1'b0);
    check("R11 launch not same edge as arm", tx_start, 1'b0);

    // R6: single pulse, busy hold-off
    do_reset();
    arm();
    fifo_bytes = 12'd500; step();
    check("R6 launch", tx_start, 1'b1);
    step();
    check("R6 pulse one cycle", tx_start, 1'b0);
    step();
    check("R6 no second pulse", tx_start, 1'b0);
    tx_done = 1; step(); tx_done = 0;
    check("R6 no pulse at done", tx_start, 1'b0);
    tx_busy = 1; step();
    check("R6 held off while busy", tx_start, 1'b0);
    tx_busy = 0; step();
    check("R6 launch after busy", tx_start, 1'b1);

    // R7: underflow while sending
    fifo_empty = 1; step(); fifo_empty = 0;
    check("R7 halted on underflow", halted, 1'b1);
    check("R7 underflow_err", underflow_err, 1'b1);
    check("R7 no jabber_err", jabber_err, 1'b0);
    step(); step();
    check("R9 underflow sticky", underflow_err, 1'b1);
    check("R2 stays halted after fault", halted, 1'b1);
    clr_underflow = 1; step(); clr_underflow = 0;
    check("R9 underflow cleared", underflow_err, 1'b0);

    // R7: empty together with done is a normal finish
    arm();
    fifo_bytes = 12'd500; step();
    check("R7 launch", tx_start, 1'b1);
    fifo_empty = 1; tx_done = 1; fifo_bytes = '0; step();
    fifo_empty = 0; tx_done = 0;
    check("R7 normal finish not halted", halted, 1'b0);
    check("R7 normal finish no error", underflow_err, 1'b0);

    // R8: jabber while armed
    jabber_to = 1; step(); jabber_to = 0;
    check("R8 halted on jabber", halted, 1'b1);
    check("R8 jabber_err", jabber_err, 1'b1);

    // R9: fault in clear cycle wins
    arm();
    jabber_to = 1; clr_jabber = 1; step(); jabber_to = 0; clr_jabber = 0;
    check("R9 set wins over clear", jabber_err, 1'b1);
    clr_jabber = 1; step(); clr_jabber = 0;
    check("R9 jabber cleared", jabber_err, 1'b0);

    // R10: run_en drop while armed, and while sending
    arm();
    check("R10 armed", halted, 1'b0);
    run_en = 0; step();
    check("R10 halt when armed", halted, 1'b1);
    arm();
    eop_written = 1; step(); eop_written = 0;
    check("R10 launch", tx_start, 1'b1);
    run_en = 0; step();
    check("R10 keeps sending", halted, 1'b0);
    tx_done = 1; step(); tx_done = 0;
    check("R10 halt at done", halted, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule